// File: doc/BRIEF.md
# Prescaled Interval Timer Bank

This block holds three interval timers for a small audio processor that runs from a 1.024 MHz master clock. Each timer divides the master clock by a fixed prescale ratio. Timers 0 and 1 use a ratio of 128 and timer 2 uses a ratio of 16. The prescaled ticks then step an 8-bit divider, which runs up to a programmable period. Each time the divider completes a period, a 4-bit counter that software reads is incremented.

Software starts and stops each timer through a level enable taken from a control register. It sets each period with a byte write. It samples a counter with a read strobe, and that read also clears the counter. A write strobe to a counter clears it as well. When a timer goes from disabled to enabled, its prescaler, its divider and its counter all start again from zero, so the first period is measured from that moment.

Top module: `timer_bank`

## Requirements
- R1: After reset every counter reads 0, and every period register holds 0, which selects a period of 256.
- R2: An enabled timer receives one prescaled tick every SLOW_DIV master clocks (timers 0 and 1) or every FAST_DIV master clocks (timer 2). The first tick comes that many clocks after the edge at which the enable is first seen high.
- R3: The period is the written byte, and the byte 0 means 256. On the tick that brings the divider to the period, the divider returns to zero and the counter increments.
- R4: The counter is 4 bits wide and wraps from 15 to 0, so after T ticks since enable it holds floor(T / period) mod 16.
- R5: A read (cnt_rd with cnt_sel = i) returns counter i on cnt_rdata in the same cycle and leaves counter i at 0 after the clock edge.
- R6: A counter write strobe (cnt_wr with cnt_sel = i) leaves counter i at 0. No data accompanies it.
- R7: On a disabled-to-enabled transition the counter, the divider and the prescaler of that timer all restart from zero.
- R8: While its enable is low, a timer never ticks, and its counter holds its value except when it is read or written.
- R9: When a read and an increment of the same counter fall on the same edge, the read returns the old value and the counter becomes 1.
- R10: Writing a period equal to the value already stored changes nothing in the count sequence.
- R11: The three timers run independently, with their own period, enable and counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 3 | Per-timer enable levels, bit i for timer i |
| per_we | input | 1 | Period write strobe |
| per_sel | input | 2 | Timer addressed by the period write |
| per_data | input | 8 | Period value, 0 meaning 256 |
| cnt_rd | input | 1 | Counter read strobe, which clears the counter |
| cnt_wr | input | 1 | Counter write strobe, which clears the counter |
| cnt_sel | input | 2 | Timer addressed by the counter read or write |
| cnt_rdata | output | 4 | Value of the selected counter, 0 for selector 3 |

## Verification
The hardest case to bring about is a read that lands on the exact edge where the counter increments. The bench enables a timer at a known negative edge, using period 1 and the fast prescaler. It then counts clock edges, so that the read strobe is high across an edge that is a multiple of the prescale ratio after the enable. That read must return the old count, and a second read on the next cycle must return 1. The bench also runs a timer whose divider was left partway through a period, disables it and enables it again, to show that the divider was cleared. Otherwise the first period after the restart would finish early.

// File: rtl/timer_bank.sv
module timer_bank #(
  parameter int SLOW_DIV = 128,
  parameter int FAST_DIV = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] en,
  input  logic       per_we,
  input  logic [1:0] per_sel,
  input  logic [7:0] per_data,
  input  logic       cnt_rd,
  input  logic       cnt_wr,
  input  logic [1:0] cnt_sel,
  output logic [3:0] cnt_rdata
);
  localparam int N    = 3;
  localparam int MAXD = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int PW   = (MAXD > 2) ? $clog2(MAXD) : 1;

  logic          en_q  [N];
  logic [PW-1:0] pre_q [N];
  logic [7:0]    per_q [N];
  logic [7:0]    dv_q  [N];
  logic [3:0]    cnt_q [N];
  logic [N-1:0]  rise, tick, inc;

  for (genvar g = 0; g < N; g++) begin : g_tmr
    localparam int DIV = (g == N - 1) ? FAST_DIV : SLOW_DIV;
    logic [8:0] plen;
    logic       hit;

    assign rise[g] = en[g] & ~en_q[g];
    assign tick[g] = en[g] & ~rise[g] & (pre_q[g] == PW'(DIV - 1));
    assign plen    = (per_q[g] == 8'd0) ? 9'd256 : {1'b0, per_q[g]};
    assign inc[g]  = tick[g] & (({1'b0, dv_q[g]} + 9'd1) == plen);
    assign hit     = (cnt_rd | cnt_wr) & (cnt_sel == 2'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[g]  <= 1'b0;
        pre_q[g] <= '0;
        per_q[g] <= 8'd0;
        dv_q[g]  <= 8'd0;
        cnt_q[g] <= 4'd0;
      end else begin
        en_q[g] <= en[g];
        if (per_we && per_sel == 2'(g) && per_data != per_q[g])
          per_q[g] <= per_data;
        if (!en[g] || rise[g] || tick[g])
          pre_q[g] <= '0;
        else
          pre_q[g] <= pre_q[g] + 1'b1;
        if (rise[g] || inc[g])
          dv_q[g] <= 8'd0;
        else if (tick[g])
          dv_q[g] <= dv_q[g] + 8'd1;
        cnt_q[g] <= ((hit || rise[g]) ? 4'd0 : cnt_q[g]) + {3'd0, inc[g]};
      end
    end
  end

  always_comb begin
    case (cnt_sel)
      2'd0:    cnt_rdata = cnt_q[0];
      2'd1:    cnt_rdata = cnt_q[1];
      2'd2:    cnt_rdata = cnt_q[2];
      default: cnt_rdata = 4'd0;
    endcase
  end
endmodule

// File: rtl/timer_bank_sva.sv
module timer_bank_sva (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] en,
  input logic       cnt_rd,
  input logic       cnt_wr,
  input logic [1:0] cnt_sel,
  input logic [2:0] inc,
  input logic [3:0] cnt0,
  input logic [3:0] cnt1,
  input logic [3:0] cnt2
);
  logic [3:0] c [3];
  assign c[0] = cnt0;
  assign c[1] = cnt1;
  assign c[2] = cnt2;

  for (genvar g = 0; g < 3; g++) begin : g_chk
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_rd && cnt_sel == 2'(g) && !inc[g]) |=> (c[g] == 4'd0));

    p_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr && cnt_sel == 2'(g) && !inc[g]) |=> (c[g] == 4'd0));

    p_enable_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en[g]) |=> (c[g] == 4'd0));

    p_disabled_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!en[g] && !((cnt_rd || cnt_wr) && cnt_sel == 2'(g))) |=> $stable(c[g]));

    p_no_inc_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
      inc[g] |-> en[g]);

    p_same_cycle_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_rd && cnt_sel == 2'(g) && inc[g]) |=> (c[g] == 4'd1));
  end
endmodule

bind timer_bank timer_bank_sva u_sva (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .cnt_rd  (cnt_rd),
  .cnt_wr  (cnt_wr),
  .cnt_sel (cnt_sel),
  .inc     (inc),
  .cnt0    (cnt_q[0]),
  .cnt1    (cnt_q[1]),
  .cnt2    (cnt_q[2])
);

// File: tb/timer_bank_tb.sv
module timer_bank_tb;
  localparam int SD = 4;
  localparam int FD = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] en = 3'd0;
  logic       per_we = 1'b0;
  logic [1:0] per_sel = 2'd0;
  logic [7:0] per_data = 8'd0;
  logic       cnt_rd = 1'b0;
  logic       cnt_wr = 1'b0;
  logic [1:0] cnt_sel = 2'd0;
  logic [3:0] cnt_rdata;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  timer_bank #(.SLOW_DIV(SD), .FAST_DIV(FD)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .per_we(per_we), .per_sel(per_sel),
    .per_data(per_data), .cnt_rd(cnt_rd), .cnt_wr(cnt_wr), .cnt_sel(cnt_sel),
    .cnt_rdata(cnt_rdata)
  );

  function automatic int divof(int i);
    return (i == 2) ? FD : SD;
  endfunction

  function automatic int expc(int i, int p, int m);
    int pe = (p == 0) ? 256 : p;
    return ((m / divof(i)) / pe) % 16;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_per(int i, int p);
    per_we = 1'b1; per_sel = 2'(i); per_data = 8'(p);
    @(negedge clk);
    per_we = 1'b0;
  endtask

  task automatic rd_cnt(int i, output int v);
    cnt_rd = 1'b1; cnt_sel = 2'(i);
    #1 v = int'(cnt_rdata);
    @(negedge clk);
    cnt_rd = 1'b0;
  endtask

  task automatic wait_edges(int m);
    repeat (m) @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    checks++; errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    int plist [7] = '{1, 2, 3, 7, 16, 255, 0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: counters clear and period 256 after reset
    for (int i = 0; i < 3; i++) begin
      rd_cnt(i, v);
      chk("R1 reset count", v, 0);
    end
    en[2] = 1'b1;
    wait_edges(511);
    rd_cnt(2, v);
    chk("R1 default period not yet", v, 0);
    wait_edges(3);
    rd_cnt(2, v);
    chk("R1 default period 256", v, 1);
    en[2] = 1'b0;
    @(negedge clk);

    // R2 R3 R4 R7: sweep of timers and periods, each run from a fresh enable
    for (int i = 0; i < 3; i++) begin
      foreach (plist[k]) begin
        int pe = (plist[k] == 0) ? 256 : plist[k];
        int m = divof(i) * (pe * 3 + pe / 2) + (k % 3);
        wr_per(i, plist[k]);
        en[i] = 1'b1;
        wait_edges(m + 1);
        rd_cnt(i, v);
        chk($sformatf("R2 R3 timer %0d period %0d", i, plist[k]), v, expc(i, plist[k], m));
        en[i] = 1'b0;
        @(negedge clk);
      end
    end

    // R4: wrap past 15
    wr_per(0, 1);
    en[0] = 1'b1;
    wait_edges(SD * 20 + 1);
    rd_cnt(0, v);
    chk("R4 wrap modulo 16", v, 4);
    en[0] = 1'b0;
    @(negedge clk);

    // R9: read coincides with increment
    wr_per(2, 1);
    en[2] = 1'b1;
    wait_edges(10);
    rd_cnt(2, v);
    chk("R9 read returns old value", v, 4);
    rd_cnt(2, v);
    chk("R9 counter became 1", v, 1);
    en[2] = 1'b0;
    @(negedge clk);

    // R5: read clears
    wr_per(1, 2);
    en[1] = 1'b1;
    wait_edges(SD * 6 + 1);
    rd_cnt(1, v);
    chk("R5 read value", v, 3);
    rd_cnt(1, v);
    chk("R5 cleared after read", v, 0);
    en[1] = 1'b0;
    @(negedge clk);

    // R6: write strobe clears
    wr_per(0, 1);
    en[0] = 1'b1;
    wait_edges(SD * 6 + 1);
    cnt_wr = 1'b1; cnt_sel = 2'd0;
    @(negedge clk);
    cnt_wr = 1'b0;
    rd_cnt(0, v);
    chk("R6 write clears", v, 0);
    en[0] = 1'b0;
    @(negedge clk);

    // R8: disabled timer holds its count
    wr_per(1, 1);
    en[1] = 1'b1;
    wait_edges(SD * 5 + 1);
    en[1] = 1'b0;
    wait_edges(50);
    rd_cnt(1, v);
    chk("R8 hold while disabled", v, 5);

    // R7: re-enable clears counter
    wr_per(1, 1);
    en[1] = 1'b1;
    wait_edges(SD * 3 + 1);
    en[1] = 1'b0;
    @(negedge clk);
    en[1] = 1'b1;
    wait_edges(3);
    rd_cnt(1, v);
    chk("R7 counter cleared on enable", v, 0);
    en[1] = 1'b0;
    @(negedge clk);

    // R7: re-enable clears a divider left partway
    wr_per(1, 3);
    en[1] = 1'b1;
    wait_edges(SD * 2 + 1);
    en[1] = 1'b0;
    @(negedge clk);
    en[1] = 1'b1;
    wait_edges(SD + 1);
    rd_cnt(1, v);
    chk("R7 divider cleared on enable", v, 0);
    wait_edges(SD * 2 - 1);
    rd_cnt(1, v);
    chk("R7 first period after restart", v, 1);
    en[1] = 1'b0;
    @(negedge clk);

    // R10: rewriting the same period has no effect
    wr_per(0, 5);
    en[0] = 1'b1;
    wait_edges(13);
    wr_per(0, 5);
    wait_edges(28);
    rd_cnt(0, v);
    chk("R10 equal period write", v, expc(0, 5, 40));
    en[0] = 1'b0;
    @(negedge clk);

    // R11: all timers at once with distinct periods
    wr_per(0, 2);
    wr_per(1, 3);
    wr_per(2, 1);
    en = 3'b111;
    wait_edges(41);
    rd_cnt(0, v);
    chk("R11 timer 0", v, expc(0, 2, 40));
    rd_cnt(1, v);
    chk("R11 timer 1", v, expc(1, 3, 41));
    rd_cnt(2, v);
    chk("R11 timer 2", v, expc(2, 1, 42));
    en = 3'b000;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule